// File: doc/BRIEF.md
# Iterative Integer Divider

This block divides one 32-bit integer by another over several clock cycles and returns either the quotient or the remainder. Each request carries a dividend, a divisor, a flag that selects two's-complement or unsigned arithmetic, a flag that selects which of the two results comes back, and an opaque tag. The block returns the tag unchanged with the result. Requests and results both use a valid/ready handshake. Only one operation is in flight at a time.

The unit first takes the magnitudes of the operands. It then runs a restoring shift-subtract loop that yields one quotient bit per cycle. After the loop it fixes the signs of the results. Two cases are decoded when the request is accepted and finish without the loop: a zero divisor, and the most negative signed value divided by minus one. Both give fixed results and raise no exception.

Top module: `int_divider`

## Requirements
- R1: When the divisor is zero, the quotient is 0xFFFFFFFF in both signed mode and unsigned mode.
- R2: When the divisor is zero, the remainder equals the dividend, unchanged, in both modes.
- R3: In signed mode, 0x80000000 divided by 0xFFFFFFFF gives a quotient of 0x80000000 and a remainder of 0.
- R4: In signed mode (in_signed=1), every other case truncates toward zero. The remainder has the sign of the dividend, so dividend = quotient*divisor + remainder.
- R5: In unsigned mode (in_signed=0), both operands are read as unsigned 32-bit values and the block returns the ordinary quotient and remainder.
- R6: in_want_rem=1 returns the remainder and in_want_rem=0 returns the quotient. The select and the tag are taken at acceptance, and out_tag equals the tag given with that request.
- R7: A request is taken only on a clock edge where in_valid and in_ready are both 1. in_ready is 0 from acceptance until the result has been taken, and it is 1 again in the cycle after that.
- R8: Once out_valid is 1, it stays 1, and out_result and out_tag stay stable, until out_ready is 1 on a clock edge. After that edge out_valid is 0.
- R9: A synchronous active-high reset drops out_valid to 0 and raises in_ready to 1, even when an operation is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle and able to take a request |
| in_dividend | input | DATA_W | Dividend |
| in_divisor | input | DATA_W | Divisor |
| in_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| in_want_rem | input | 1 | 1 = return remainder, 0 = return quotient |
| in_tag | input | TAG_W | Opaque tag carried with the request |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | DATA_W | Quotient or remainder |
| out_tag | output | TAG_W | Tag of the returned request |

## Verification
The checker module tests these rules on every cycle:
- A result is held stable while the consumer stalls it.
- in_ready and out_valid are never 1 together.
- A new request is never taken while one is in flight.
- Reset clears the output.
- A zero divisor, signed overflow and unsigned division give the right values, checked against operands latched at acceptance.

Only the bench's scenarios show the following:
- Signed truncation and the sign of the remainder across mixed-sign operands.
- Return of the tag for each request.
- Reset arriving partway through the loop.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } div_state_e;

  function automatic logic [31:0] cnt_unused(input logic [31:0] v);
    return v;
  endfunction
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  input  logic         is_signed,
  output logic [W-1:0] mag_dvd,
  output logic [W-1:0] mag_dsr,
  output logic         flip_quo,
  output logic         flip_rem,
  output logic         zero_dsr,
  output logic         ovf
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic dvd_neg, dsr_neg;

  always_comb begin
    dvd_neg  = is_signed & dividend[W-1];
    dsr_neg  = is_signed & divisor[W-1];
    mag_dvd  = dvd_neg ? (~dividend + 1'b1) : dividend;
    mag_dsr  = dsr_neg ? (~divisor + 1'b1) : divisor;
    flip_quo = dvd_neg ^ dsr_neg;
    flip_rem = dvd_neg;
    zero_dsr = (divisor == '0);
    ovf      = is_signed && (dividend == MOST_NEG) && (divisor == '1);
  end
endmodule

// File: rtl/div_restoring_core.sv
module div_restoring_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         done
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  den_q;
  logic [W:0]    trial, diff;
  logic          borrow;

  always_comb begin
    trial  = {rem, quo[W-1]};
    diff   = trial - {1'b0, den_q};
    borrow = diff[W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      done  <= 1'b0;
      quo   <= '0;
      rem   <= '0;
      den_q <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem   <= '0;
        quo   <= num;
        den_q <= den;
        cnt   <= CW'(W);
      end else if (cnt != '0) begin
        rem  <= borrow ? trial[W-1:0] : diff[W-1:0];
        quo  <= {quo[W-2:0], ~borrow};
        cnt  <= cnt - 1'b1;
        done <= (cnt == CW'(1));
      end
    end
  end
endmodule

// File: rtl/int_divider.sv
module int_divider #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_dividend,
  input  logic [DATA_W-1:0] in_divisor,
  input  logic              in_signed,
  input  logic              in_want_rem,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [TAG_W-1:0]  out_tag
);
  import div_pkg::*;

  div_state_e state;
  logic [DATA_W-1:0] mag_dvd, mag_dsr, core_quo, core_rem;
  logic flip_quo, flip_rem, zero_dsr, ovf, core_done, accept, core_start;
  logic flip_quo_q, flip_rem_q, want_rem_q;

  div_operand_prep #(.W(DATA_W)) u_prep (
    .dividend (in_dividend),
    .divisor  (in_divisor),
    .is_signed(in_signed),
    .mag_dvd  (mag_dvd),
    .mag_dsr  (mag_dsr),
    .flip_quo (flip_quo),
    .flip_rem (flip_rem),
    .zero_dsr (zero_dsr),
    .ovf      (ovf)
  );

  assign accept     = in_valid && (state == ST_IDLE);
  assign core_start = accept && !zero_dsr && !ovf;

  div_restoring_core #(.W(DATA_W)) u_core (
    .clk  (clk),
    .rst  (rst),
    .start(core_start),
    .num  (mag_dvd),
    .den  (mag_dsr),
    .quo  (core_quo),
    .rem  (core_rem),
    .done (core_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      out_result <= '0;
      out_tag    <= '0;
      want_rem_q <= 1'b0;
      flip_quo_q <= 1'b0;
      flip_rem_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          out_tag    <= in_tag;
          want_rem_q <= in_want_rem;
          flip_quo_q <= flip_quo;
          flip_rem_q <= flip_rem;
          if (zero_dsr) begin
            out_result <= in_want_rem ? in_dividend : '1;
            state      <= ST_DONE;
          end else if (ovf) begin
            out_result <= in_want_rem ? '0 : in_dividend;
            state      <= ST_DONE;
          end else begin
            state <= ST_RUN;
          end
        end
        ST_RUN: if (core_done) begin
          if (want_rem_q)
            out_result <= flip_rem_q ? (~core_rem + 1'b1) : core_rem;
          else
            out_result <= flip_quo_q ? (~core_quo + 1'b1) : core_quo;
          state <= ST_DONE;
        end
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);
endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int W     = 32,
  parameter int TAG_W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_dividend,
  input logic [W-1:0] in_divisor,
  input logic         in_signed,
  input logic         in_want_rem,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_result,
  input logic [TAG_W-1:0] out_tag
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] c_dvd, c_dsr;
  logic c_sg, c_rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_dvd <= '0; c_dsr <= '0; c_sg <= 1'b0; c_rem <= 1'b0;
    end else if (in_valid && in_ready) begin
      c_dvd <= in_dividend; c_dsr <= in_divisor;
      c_sg  <= in_signed;   c_rem <= in_want_rem;
    end
  end

  AST_ZERO_QUO: assert property (@(posedge clk) disable iff (rst)
    out_valid && c_dsr == '0 && !c_rem |-> out_result == '1); // R1
  AST_ZERO_REM: assert property (@(posedge clk) disable iff (rst)
    out_valid && c_dsr == '0 && c_rem |-> out_result == c_dvd); // R2
  AST_SIGNED_OVF: assert property (@(posedge clk) disable iff (rst)
    out_valid && c_sg && c_dvd == MOST_NEG && c_dsr == '1 |-> out_result == (c_rem ? '0 : MOST_NEG)); // R3
  AST_UNSIGNED_VAL: assert property (@(posedge clk) disable iff (rst)
    out_valid && !c_sg && c_dsr != '0 |-> out_result == (c_rem ? c_dvd % c_dsr : c_dvd / c_dsr)); // R5
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> !in_ready); // R7
  AST_READY_VALID_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid)); // R7
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_tag)); // R8
  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready |=> !out_valid && in_ready); // R8
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !out_valid && in_ready); // R9
endmodule

bind int_divider div_checker #(.W(DATA_W), .TAG_W(TAG_W)) u_div_checker (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_dividend(in_dividend),
  .in_divisor (in_divisor),
  .in_signed  (in_signed),
  .in_want_rem(in_want_rem),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_tag    (out_tag)
);

// File: tb/test_int_divider.sv
module test_int_divider;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 32;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_signed = 1'b0, in_want_rem = 1'b0, out_ready = 1'b0;
  logic [W-1:0] in_dividend = '0, in_divisor = '0;
  logic [TW-1:0] in_tag = '0;
  logic in_ready, out_valid;
  logic [W-1:0] out_result;
  logic [TW-1:0] out_tag;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_divider #(.DATA_W(W), .TAG_W(TW)) i_int_divider (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_dividend(in_dividend), .in_divisor(in_divisor), .in_signed(in_signed),
    .in_want_rem(in_want_rem), .in_tag(in_tag), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_tag(out_tag)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic sg, input logic rm);
    if (b == '0) return rm ? a : '1;
    if (sg && a == 32'h8000_0000 && b == '1) return rm ? '0 : a;
    if (sg) return rm ? W'($signed(a) % $signed(b)) : W'($signed(a) / $signed(b));
    return rm ? a % b : a / b;
  endfunction

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic sg,
                        input logic rm, input logic [TW-1:0] tg, input int stall,
                        input string req);
    logic [W-1:0] held;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_dividend = a; in_divisor = b;
    in_signed = sg; in_want_rem = rm; in_tag = tg;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 busy after accept", in_ready, 0);
    while (!out_valid) @(negedge clk);
    held = out_result;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check("R8 valid held", out_valid, 1);
      check("R8 result held", out_result, held);
    end
    check(req, out_result, model(a, b, sg, rm));
    check("R6 tag", out_tag, tg);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    check("R8 released", out_valid, 0);
    check("R7 ready again", in_ready, 1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R9 out_valid after reset", out_valid, 0);
    check("R9 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_reset_midway();
    @(negedge clk);
    in_valid = 1'b1; in_dividend = 32'd1000; in_divisor = 32'd7;
    in_signed = 1'b0; in_want_rem = 1'b0; in_tag = 8'h11;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 reset mid-op out_valid", out_valid, 0);
    check("R9 reset mid-op in_ready", in_ready, 1);
  endtask

  task automatic t_div_zero();
    for (int m = 0; m < 2; m++) begin
      run_op(32'h1234_5678, '0, m[0], 1'b0, 8'h20, 0, "R1 zero divisor quotient");
      run_op(32'hDEAD_BEEF, '0, m[0], 1'b1, 8'h21, 1, "R2 zero divisor remainder");
      run_op('0, '0, m[0], 1'b1, 8'h22, 0, "R2 zero by zero remainder");
    end
  endtask

  task automatic t_overflow();
    run_op(32'h8000_0000, '1, 1'b1, 1'b0, 8'h30, 0, "R3 overflow quotient");
    run_op(32'h8000_0000, '1, 1'b1, 1'b1, 8'h31, 2, "R3 overflow remainder");
    run_op(32'h8000_0000, '1, 1'b0, 1'b0, 8'h32, 0, "R5 unsigned same operands quotient");
    run_op(32'h8000_0000, '1, 1'b0, 1'b1, 8'h33, 0, "R5 unsigned same operands remainder");
  endtask

  task automatic t_signed();
    run_op(-32'sd7, 32'sd2, 1'b1, 1'b0, 8'h40, 0, "R4 -7/2 quotient");
    run_op(-32'sd7, 32'sd2, 1'b1, 1'b1, 8'h41, 0, "R4 -7/2 remainder");
    run_op(32'sd7, -32'sd2, 1'b1, 1'b1, 8'h42, 0, "R4 7/-2 remainder");
    run_op(-32'sd7, -32'sd2, 1'b1, 1'b0, 8'h43, 0, "R4 -7/-2 quotient");
    run_op(32'h8000_0000, 32'sd1, 1'b1, 1'b0, 8'h44, 0, "R4 min/1 quotient");
    for (int i = 0; i < 60; i++)
      run_op($urandom, $urandom >> ($urandom % 32), 1'b1, i[0], TW'(i), 0, "R4 random signed");
  endtask

  task automatic t_unsigned();
    run_op('1, 32'd1, 1'b0, 1'b0, 8'h50, 0, "R5 max/1");
    run_op(32'd5, 32'hFFFF_FFFF, 1'b0, 1'b1, 8'h51, 0, "R5 small/max remainder");
    for (int i = 0; i < 60; i++)
      run_op($urandom, $urandom >> ($urandom % 32), 1'b0, i[1], TW'(i + 100), 0, "R5 random unsigned");
  endtask

  task automatic t_select();
    run_op(32'd100, 32'd7, 1'b0, 1'b0, 8'hA5, 0, "R6 select quotient");
    run_op(32'd100, 32'd7, 1'b0, 1'b1, 8'h5A, 0, "R6 select remainder");
  endtask

  task automatic t_backpressure();
    for (int i = 0; i < 20; i++)
      run_op($urandom, $urandom >> 8, i[0], i[1], TW'(200 + i), int'($urandom % 5), "R8 stalled result");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_div_zero();
    t_overflow();
    t_signed();
    t_unsigned();
    t_select();
    t_backpressure();
    t_reset_midway();
    t_select();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule